// File: doc/BRIEF.md
# Dual Match Timer with Coherent Wide Counter

This peripheral gives software two independent 32-bit compare channels and one free-running 64-bit time base, all reached through a plain register bus. The bus has 32-bit data and byte offsets. Each channel counts up by one per clock while enabled. When the count reaches the channel's programmed compare value, the channel sets a sticky status flag. That flag drives a level interrupt for the channel when the channel's interrupt-enable bit is set. Software typically disables the channel, writes the count to zero, writes a new compare value and enables it again to arm the next event.

The 64-bit time base never stops. It cannot be read atomically over a 32-bit bus, so software first writes a capture command. The command freezes the current count into a pair of snapshot registers, and software then reads both halves at leisure. A second command reloads the running count from a pair of preload registers. Channel flags share a single status word in which writing a one clears a flag.

Top module: `match_timer`

## Requirements
- R1: After reset every register reads zero except the live 64-bit count, and both interrupt outputs are low.
- R2: Channel n has a control word at byte offset 0x00+4n, a compare word at 0x18+4n and a count word at 0x48+4n. The count increments by one per clock while control bit 0 is set, holds while it is clear, and takes the written value in a cycle where software writes it. Control bits 2:0 read back as written.
- R3: Status bit n at offset 0x60 becomes set on the clock edge after a cycle in which channel n is enabled and its count equals its compare value. The bit then stays set until software clears it.
- R4: Interrupt output bit n is high exactly while status bit n is set and control bit 1 of channel n is set.
- R5: Writing the status word clears each status bit written as one and leaves bits written as zero. Writing 0xFFFF clears every flag.
- R6: When a clear of status bit n arrives in the same cycle as a new match on channel n, the bit stays set.
- R7: The 64-bit count increments every clock. Its low and high halves read at 0x6C and 0x70.
- R8: Writing the wide control word at 0x68 with bit 0 set and bit 1 clear copies the count of that cycle into the snapshot halves at 0x7C (low) and 0x80 (high).
- R9: Writing 0x68 with bits 1:0 both set makes the count equal the preload pair (low at 0x74, high at 0x78) on the next clock. Counting then continues from that value, with the carry crossing into the high half.
- R10: The wide control word reads as zero. A write to it with bit 0 clear changes neither the snapshot nor the count sequence.
- R11: Reads of unmapped or misaligned offsets, including 0x64, return zero, and writes to them change nothing.
- R12: A compare distance of 2 works: after the count is written to 0 with compare value 2, the status bit is still clear two clocks later and set three clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Byte offset of the access |
| busWr | input | 1 | Write strobe, sampled on the rising edge |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| irq | output | 2 | Level interrupt per channel |

## Verification
The compare channels are driven with one channel that has its interrupt enabled and one that is masked, with short and long compare distances. This separates the flag logic from the interrupt gating. A clear is timed to land on the exact cycle of a fresh match, which tells set-wins from clear-wins. The wide counter is exercised with captures taken while it runs, a preload just below a 32-bit carry, and a command word with bit 0 clear. Together these show whether capture, reload and plain counting are told apart by the command bits.

// File: rtl/match_timer_pkg.sv
package match_timer_pkg;

  // Register kinds resolved by the address decoder
  typedef enum logic [3:0] {
    RK_NONE,
    RK_CH_CTRL,
    RK_CH_MATCH,
    RK_CH_CNT,
    RK_STATUS,
    RK_WIDE_CTRL,
    RK_LIVE_LO,
    RK_LIVE_HI,
    RK_LOAD_LO,
    RK_LOAD_HI,
    RK_SNAP_LO,
    RK_SNAP_HI
  } regKind_e;

  localparam int IDX_W  = 3;
  localparam int MAX_CH = 6;   // channel windows below overlap beyond this

  // Word indices (byte offset / 4)
  localparam int CH_CTRL_WORD   = 0;
  localparam int CH_MATCH_WORD  = 6;
  localparam int CH_CNT_WORD    = 18;
  localparam int STATUS_WORD    = 24;
  localparam int WIDE_CTRL_WORD = 26;
  localparam int LIVE_LO_WORD   = 27;
  localparam int LIVE_HI_WORD   = 28;
  localparam int LOAD_LO_WORD   = 29;
  localparam int LOAD_HI_WORD   = 30;
  localparam int SNAP_LO_WORD   = 31;
  localparam int SNAP_HI_WORD   = 32;

  // Strobes from control to datapath
  typedef struct packed {
    regKind_e         kind;
    logic [IDX_W-1:0] idx;
    logic             wr;
    logic             snapCmd;
    logic             loadCmd;
  } busOp_t;

endpackage

// File: rtl/match_timer_ctrl.sv
module match_timer_ctrl
  import match_timer_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [1:0]        cmdBits,
  output busOp_t            op
);

  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  regKind_e          kind;
  logic [IDX_W-1:0]  idx;

  assign word = busAddr[ADDR_W-1:2];

  always_comb begin
    kind = RK_NONE;
    idx  = '0;
    if (busAddr[1:0] == 2'b00) begin
      case (int'(word))
        STATUS_WORD:    kind = RK_STATUS;
        WIDE_CTRL_WORD: kind = RK_WIDE_CTRL;
        LIVE_LO_WORD:   kind = RK_LIVE_LO;
        LIVE_HI_WORD:   kind = RK_LIVE_HI;
        LOAD_LO_WORD:   kind = RK_LOAD_LO;
        LOAD_HI_WORD:   kind = RK_LOAD_HI;
        SNAP_LO_WORD:   kind = RK_SNAP_LO;
        SNAP_HI_WORD:   kind = RK_SNAP_HI;
        default:        kind = RK_NONE;
      endcase
      for (int n = 0; n < NUM_CH; n++) begin
        if (int'(word) == CH_CTRL_WORD + n) begin
          kind = RK_CH_CTRL;
          idx  = IDX_W'(n);
        end
        if (int'(word) == CH_MATCH_WORD + n) begin
          kind = RK_CH_MATCH;
          idx  = IDX_W'(n);
        end
        if (int'(word) == CH_CNT_WORD + n) begin
          kind = RK_CH_CNT;
          idx  = IDX_W'(n);
        end
      end
    end
  end

  always_comb begin
    op.kind    = kind;
    op.idx     = idx;
    op.wr      = busWr;
    op.snapCmd = busWr && (kind == RK_WIDE_CTRL) && (cmdBits == 2'b01);
    op.loadCmd = busWr && (kind == RK_WIDE_CTRL) && (cmdBits == 2'b11);
  end

endmodule

// File: rtl/match_timer_dp.sv
module match_timer_dp
  import match_timer_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DATA_W = 32,
  parameter int CTRL_W = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  busOp_t              op,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  output logic [NUM_CH-1:0]   irq,
  output logic [NUM_CH-1:0]   chStatus,
  output logic [NUM_CH-1:0]   chEnable,
  output logic [2*DATA_W-1:0] wideCount
);

  localparam int WIDE_W = 2 * DATA_W;

  logic [CTRL_W-1:0] ctrlArr  [NUM_CH];
  logic [DATA_W-1:0] matchArr [NUM_CH];
  logic [DATA_W-1:0] countArr [NUM_CH];
  logic [NUM_CH-1:0] hit;
  logic [NUM_CH-1:0] clrMask;
  logic [NUM_CH-1:0] statusQ;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [CTRL_W-1:0] ctrlQ;
    logic [DATA_W-1:0] matchQ;
    logic [DATA_W-1:0] countQ;
    logic              selMe;

    assign selMe = op.wr && (op.idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ctrlQ  <= '0;
        matchQ <= '0;
        countQ <= '0;
      end else begin
        if (selMe && op.kind == RK_CH_CTRL)  ctrlQ  <= busWdata[CTRL_W-1:0];
        if (selMe && op.kind == RK_CH_MATCH) matchQ <= busWdata;
        if (selMe && op.kind == RK_CH_CNT)   countQ <= busWdata;
        else if (ctrlQ[0])                   countQ <= countQ + 1'b1;
      end
    end

    assign hit[g]      = ctrlQ[0] && (countQ == matchQ);
    assign irq[g]      = statusQ[g] && ctrlQ[1];
    assign chEnable[g] = ctrlQ[0];
    assign ctrlArr[g]  = ctrlQ;
    assign matchArr[g] = matchQ;
    assign countArr[g] = countQ;
  end

  // Write-one-to-clear, new match wins over a simultaneous clear
  assign clrMask = (op.wr && op.kind == RK_STATUS) ? busWdata[NUM_CH-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= (statusQ & ~clrMask) | hit;
  end

  assign chStatus = statusQ;

  // Wide time base
  logic [WIDE_W-1:0] wideQ;
  logic [WIDE_W-1:0] snapQ;
  logic [DATA_W-1:0] loadLoQ;
  logic [DATA_W-1:0] loadHiQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wideQ   <= '0;
      snapQ   <= '0;
      loadLoQ <= '0;
      loadHiQ <= '0;
    end else begin
      if (op.loadCmd) wideQ <= {loadHiQ, loadLoQ};
      else            wideQ <= wideQ + 1'b1;
      if (op.snapCmd) snapQ <= wideQ;
      if (op.wr && op.kind == RK_LOAD_LO) loadLoQ <= busWdata;
      if (op.wr && op.kind == RK_LOAD_HI) loadHiQ <= busWdata;
    end
  end

  assign wideCount = wideQ;

  // Read path
  logic [CTRL_W-1:0] ctrlSel;
  logic [DATA_W-1:0] matchSel;
  logic [DATA_W-1:0] countSel;

  always_comb begin
    ctrlSel  = '0;
    matchSel = '0;
    countSel = '0;
    for (int n = 0; n < NUM_CH; n++) begin
      if (op.idx == IDX_W'(n)) begin
        ctrlSel  = ctrlArr[n];
        matchSel = matchArr[n];
        countSel = countArr[n];
      end
    end
  end

  always_comb begin
    case (op.kind)
      RK_CH_CTRL:  busRdata = DATA_W'(ctrlSel);
      RK_CH_MATCH: busRdata = matchSel;
      RK_CH_CNT:   busRdata = countSel;
      RK_STATUS:   busRdata = DATA_W'(statusQ);
      RK_LIVE_LO:  busRdata = wideQ[DATA_W-1:0];
      RK_LIVE_HI:  busRdata = wideQ[WIDE_W-1:DATA_W];
      RK_LOAD_LO:  busRdata = loadLoQ;
      RK_LOAD_HI:  busRdata = loadHiQ;
      RK_SNAP_LO:  busRdata = snapQ[DATA_W-1:0];
      RK_SNAP_HI:  busRdata = snapQ[WIDE_W-1:DATA_W];
      default:     busRdata = '0;
    endcase
  end

endmodule

// File: rtl/match_timer.sv
module match_timer
  import match_timer_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [NUM_CH-1:0] irq
);

  busOp_t              op;
  logic [NUM_CH-1:0]   chStatus;
  logic [NUM_CH-1:0]   chEnable;
  logic [2*DATA_W-1:0] wideCount;

  match_timer_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .busWr   (busWr),
    .cmdBits (busWdata[1:0]),
    .op      (op)
  );

  match_timer_dp #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .op        (op),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .irq       (irq),
    .chStatus  (chStatus),
    .chEnable  (chEnable),
    .wideCount (wideCount)
  );

endmodule

// File: rtl/match_timer_chk.sv
module match_timer_chk
  import match_timer_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rstN,
  input regKind_e            kind,
  input logic                wrEn,
  input logic                loadCmd,
  input logic [DATA_W-1:0]   busRdata,
  input logic [NUM_CH-1:0]   chStatus,
  input logic [NUM_CH-1:0]   chEnable,
  input logic [2*DATA_W-1:0] wideCount
);

  // R7
  wide_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !loadCmd |=> wideCount == $past(wideCount) + 1'b1);

  // R11
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (kind == RK_NONE) |-> (busRdata == '0));

  // R10
  cmd_readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    (kind == RK_WIDE_CTRL) |-> (busRdata == '0));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    // R3
    status_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (chStatus[g] && !(wrEn && kind == RK_STATUS)) |=> chStatus[g]);

    // R3
    status_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(chStatus[g]) |-> $past(chEnable[g]));
  end

endmodule

bind match_timer match_timer_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .kind      (op.kind),
  .wrEn      (op.wr),
  .loadCmd   (op.loadCmd),
  .busRdata  (busRdata),
  .chStatus  (chStatus),
  .chEnable  (chEnable),
  .wideCount (wideCount)
);

// File: tb/match_timer_tb.sv
`timescale 1ns/1ps
module match_timer_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  addr = 8'h64;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] busRdata;
  logic [1:0]  irq;

  int nChecks = 0;
  int nErr = 0;
  bit runChk = 1'b0;

  always #2 clk = ~clk;

  match_timer u_dut (
    .clk(clk), .rstN(rstN), .busAddr(addr), .busWr(we),
    .busWdata(wdata), .busRdata(busRdata), .irq(irq)
  );

  // Behavioural reference model
  logic [2:0]  mCtrl [2];
  logic [31:0] mMatch [2];
  logic [31:0] mCnt [2];
  logic [1:0]  mStat;
  logic [63:0] mWide, mSnap;
  logic [31:0] mLoadLo, mLoadHi;

  always @(posedge clk) begin : model
    logic [1:0] hitV;
    logic [1:0] clr;
    if (!rstN) begin
      for (int n = 0; n < 2; n++) begin
        mCtrl[n] = '0; mMatch[n] = '0; mCnt[n] = '0;
      end
      mStat = '0; mWide = '0; mSnap = '0; mLoadLo = '0; mLoadHi = '0;
    end else begin
      for (int n = 0; n < 2; n++)
        hitV[n] = mCtrl[n][0] && (mCnt[n] == mMatch[n]);
      if (we && addr == 8'h68 && wdata[1:0] == 2'b01) mSnap = mWide;
      if (we && addr == 8'h68 && wdata[1:0] == 2'b11) mWide = {mLoadHi, mLoadLo};
      else mWide = mWide + 64'd1;
      if (we && addr == 8'h74) mLoadLo = wdata;
      if (we && addr == 8'h78) mLoadHi = wdata;
      clr = (we && addr == 8'h60) ? wdata[1:0] : 2'b00;
      mStat = (mStat & ~clr) | hitV;
      for (int n = 0; n < 2; n++) begin
        if (we && addr == 8'(72 + 4 * n)) mCnt[n] = wdata;
        else if (mCtrl[n][0]) mCnt[n] = mCnt[n] + 32'd1;
        if (we && addr == 8'(4 * n)) mCtrl[n] = wdata[2:0];
        if (we && addr == 8'(24 + 4 * n)) mMatch[n] = wdata;
      end
    end
  end

  function automatic logic [31:0] mdlRead(input logic [7:0] a);
    case (a)
      8'h00: return {29'd0, mCtrl[0]};
      8'h04: return {29'd0, mCtrl[1]};
      8'h18: return mMatch[0];
      8'h1C: return mMatch[1];
      8'h48: return mCnt[0];
      8'h4C: return mCnt[1];
      8'h60: return {30'd0, mStat};
      8'h6C: return mWide[31:0];
      8'h70: return mWide[63:32];
      8'h74: return mLoadLo;
      8'h78: return mLoadHi;
      8'h7C: return mSnap[31:0];
      8'h80: return mSnap[63:32];
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R4: interrupt lines compared on every clock
  always @(negedge clk) begin
    if (rstN && runChk) begin
      logic [1:0] mIrq;
      for (int n = 0; n < 2; n++) mIrq[n] = mStat[n] && mCtrl[n][1];
      check("R4 irq", {30'd0, irq}, {30'd0, mIrq});
    end
  end

  // Called at a falling edge; returns at the next falling edge
  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; addr = 8'h64;
  endtask

  task automatic busRead(input logic [7:0] a, input string tag);
    addr = a; we = 1'b0;
    #1;
    check(tag, busRdata, mdlRead(a));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nErr++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    runChk = 1'b1;
    idle(1);

    // R1 reset state
    busRead(8'h00, "R1 ctrl0");
    check("R1 ctrl0 literal", busRdata, 32'd0);
    busRead(8'h60, "R1 status");
    busRead(8'h7C, "R1 snap lo");
    busRead(8'h4C, "R1 cnt1");
    check("R1 irq", {30'd0, irq}, 32'd0);

    // R2/R3/R4: channel 0 with interrupt, channel 1 masked
    busWrite(8'h18, 32'd5);
    busWrite(8'h1C, 32'd3);
    busWrite(8'h48, 32'd0);
    busWrite(8'h4C, 32'd0);
    busWrite(8'h00, 32'h3);
    busWrite(8'h04, 32'h1);
    busRead(8'h00, "R2 ctrl0 readback");
    idle(2);
    busRead(8'h48, "R2 cnt0 running");
    busRead(8'h60, "R3 status early");
    idle(6);
    busRead(8'h60, "R3 status both set");
    check("R4 irq masked ch1", {30'd0, irq}, 32'h1);

    // R2 hold when disabled
    busWrite(8'h04, 32'h0);
    busRead(8'h4C, "R2 cnt1 hold a");
    idle(3);
    busRead(8'h4C, "R2 cnt1 hold b");

    // R5 selective and full clear
    busWrite(8'h60, 32'h1);
    busRead(8'h60, "R5 clear bit0 only");
    busWrite(8'h60, 32'hFFFF);
    busRead(8'h60, "R5 clear all");

    // R6 clear lands on the cycle of a fresh match
    busWrite(8'h18, 32'd10);
    busWrite(8'h48, 32'd0);
    idle(10);
    busWrite(8'h60, 32'h1);
    busRead(8'h60, "R6 set wins");
    check("R6 literal", busRdata & 32'h1, 32'h1);
    busWrite(8'h60, 32'hFFFF);

    // R12 compare distance of 2
    busWrite(8'h18, 32'd2);
    busWrite(8'h48, 32'd0);
    idle(2);
    busRead(8'h60, "R12 not yet");
    check("R12 literal clear", busRdata & 32'h1, 32'h0);
    idle(1);
    busRead(8'h60, "R12 set");
    check("R12 literal set", busRdata & 32'h1, 32'h1);

    // R7 live wide count
    busRead(8'h6C, "R7 live lo a");
    idle(5);
    busRead(8'h6C, "R7 live lo b");
    busRead(8'h70, "R7 live hi");

    // R8 snapshot
    busWrite(8'h68, 32'h1);
    idle(3);
    busRead(8'h7C, "R8 snap lo");
    busRead(8'h80, "R8 snap hi");

    // R9 preload near a low-word carry
    busWrite(8'h74, 32'hFFFF_FFFE);
    busWrite(8'h78, 32'h0000_0012);
    busWrite(8'h68, 32'h3);
    busRead(8'h6C, "R9 loaded lo");
    busRead(8'h70, "R9 loaded hi");
    idle(3);
    busRead(8'h6C, "R9 after carry lo");
    busRead(8'h70, "R9 after carry hi");
    check("R9 literal hi", busRdata, 32'h13);

    // R10 command word reads zero, bit0-clear write is inert
    busRead(8'h68, "R10 readback");
    busWrite(8'h68, 32'h2);
    busRead(8'h7C, "R10 snap unchanged");
    busRead(8'h6C, "R10 count unchanged");

    // R11 unmapped and misaligned
    busWrite(8'h64, 32'hFFFF_FFFF);
    busRead(8'h64, "R11 read 0x64");
    busWrite(8'h02, 32'h7);
    busRead(8'h00, "R11 misaligned write ignored");
    busRead(8'h02, "R11 misaligned read");
    busWrite(8'h84, 32'h1234);
    busRead(8'h84, "R11 read 0x84");
    busRead(8'hF0, "R11 read 0xF0");

    idle(2);
    runChk = 1'b0;
    finishRun();
  end

endmodule